// File: doc/BRIEF.md
# Bus-Master Disk DMA Control Register Block

This block holds the programmable state for two disk-controller DMA channels behind a 16-byte I/O window. Each channel owns an 8-byte slice. Channel 0 starts at window offset 0x0 and channel 1 at offset 0x8. In each slice, offset 0 is the command byte and offset 2 is the status byte. Offsets 4 to 7 hold a 32-bit pointer to the channel's transfer descriptor table.

Software reaches the block through a simple I/O port: address, write strobe, write data, a 2-bit access-size code and a registered read-data bus. A DMA engine outside the block sees each channel's start bit, direction bit and descriptor pointer. The engine reports back through three inputs per channel: an active level, an interrupt pulse and an error pulse.

The command and status bytes accept only single-byte accesses. The status byte mixes three kinds of bit: some are cleared by writing one, some are plain read/write, and one is owned by the engine.

Top module: `ide_busmaster_regs`

## Requirements
- R1: Address bit 3 selects the channel (0x0 to 0x7 is channel 0, 0x8 to 0xF is channel 1). Address bit 2 set selects the descriptor pointer; address bit 2 clear selects the command/status area. A write to one channel never changes the other channel.
- R2: A byte read (size code 0) of the command/status area returns data zero-extended to 32 bits. The byte offset address[1:0] picks the data: 0 returns the command byte, 2 returns the status byte, 1 or 3 returns 0xFF.
- R3: A read of the command/status area with size code 1 (halfword) returns 0x0000FFFF. With size code 2 or 3 (word) it returns 0xFFFFFFFF.
- R4: A write to the command/status area with any size code other than 0 has no effect.
- R5: A byte write at offset 0 stores bit 0 as the start bit and bit 3 as the direction bit. Both appear on ch_start/ch_dir after the edge. The command byte reads back as only these two bits, all other bits 0.
- R6: A byte write at offset 2 loads status bits 6:5 from the write data. Status bits 7, 4 and 3 always read 0.
- R7: Status bit 0 follows the channel's eng_active input with one cycle of delay, and status writes never change it.
- R8: On a status write, bit 2 (interrupt) and bit 1 (error) are cleared where the write data has a 1, and are kept where it has a 0.
- R9: An eng_irq pulse sets status bit 2 and an eng_err pulse sets status bit 1. If a pulse arrives in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R10: Pointer writes work at sizes of byte, halfword or word. The write data's low bytes fill pointer bytes starting at offset address[1:0]. Bytes that would fall past offset 7 are dropped. Pointer bits 1:0 always read 0.
- R11: A pointer read returns the pointer shifted right by 8 × address[1:0], then masked to the access size (0xFF, 0xFFFF or all 32 bits).
- R12: Reset clears the command, status and pointer of both channels, and clears the read-data register.
- R13: Read data appears one clock after the address is presented. Reading never changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Byte address in the window |
| io_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 or 3 word |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data, least significant byte first |
| io_rdata | output | 32 | Registered read data |
| eng_active | input | 2 | Engine busy level per channel |
| eng_irq | input | 2 | Interrupt event pulse per channel |
| eng_err | input | 2 | Error event pulse per channel |
| ch_start | output | 2 | Start bit per channel |
| ch_dir | output | 2 | Direction bit per channel |
| ch_ptr | output | 64 | Descriptor pointers, channel 0 in bits 31:0 |

## Verification
The hardest case to reach from the ports is an engine event landing in the same clock as a write-one-to-clear of the same status bit. The bench therefore drives eng_irq and eng_err in the exact cycle that carries a status write with those bits set, and then reads the status back.

A related hard case is the halfword pointer write that straddles offset 7. The bench aims halfword writes at offsets 6 and 7 so that the dropped lane becomes visible on ch_ptr.

The engine-owned active bit is checked by holding eng_active high across status writes whose bit 0 is clear.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } io_size_e;

    localparam int SLICE_BYTES = 8;
    localparam int CMD_OFF     = 0;
    localparam int STS_OFF     = 2;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;

    localparam int ST_ACT_BIT = 0;
    localparam int ST_ERR_BIT = 1;
    localparam int ST_IRQ_BIT = 2;
    localparam logic [7:0] ST_RW_MASK = 8'h60;

    function automatic logic [31:0] size_mask(io_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int size_bytes(io_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

    typedef struct packed {
        logic       start;
        logic       dir;
        logic [7:0] sts;
    } chan_state_t;

    typedef struct packed {
        logic [31:0] ptr;
    } ptr_state_t;

endpackage

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
    import ide_bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic       sts_we,
    input  logic [7:0] wbyte,
    input  logic       eng_active,
    input  logic       eng_irq,
    input  logic       eng_err,
    output logic       start,
    output logic       dir,
    output logic [7:0] sts
);

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sts[ST_ACT_BIT] = eng_active;
        if (cmd_we) begin
            st_d.start = wbyte[CMD_START_BIT];
            st_d.dir   = wbyte[CMD_DIR_BIT];
        end
        if (sts_we) begin
            st_d.sts[6:5] = wbyte[6:5];
            st_d.sts[ST_IRQ_BIT:ST_ERR_BIT] =
                st_q.sts[ST_IRQ_BIT:ST_ERR_BIT] & ~wbyte[ST_IRQ_BIT:ST_ERR_BIT];
        end
        if (eng_irq) st_d.sts[ST_IRQ_BIT] = 1'b1;
        if (eng_err) st_d.sts[ST_ERR_BIT] = 1'b1;
        st_d.sts[7] = 1'b0;
        st_d.sts[4] = 1'b0;
        st_d.sts[3] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start = st_q.start;
    assign dir   = st_q.dir;
    assign sts   = st_q.sts;

    // R5: command write lands on the start output next cycle
    a_r5_cmd_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (start == $past(wbyte[CMD_START_BIT])));

    // R8: writing one clears the interrupt flag when no event competes
    a_r8_w1c_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && wbyte[ST_IRQ_BIT] && !eng_irq) |=> !sts[ST_IRQ_BIT]);

    // R9: an event always leaves its flag set
    a_r9_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
        eng_irq |=> sts[ST_IRQ_BIT]);

    a_r9_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> sts[ST_ERR_BIT]);

endmodule

// File: rtl/ide_bm_ptr.sv
module ide_bm_ptr
    import ide_bm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  off,
    input  io_size_e    size,
    input  logic [31:0] wdata,
    output logic [31:0] ptr
);

    ptr_state_t ps_d, ps_q;
    int         nbytes;
    int         lane;

    always_comb begin
        ps_d   = ps_q;
        nbytes = size_bytes(size);
        lane   = 0;
        for (int j = 0; j < 4; j++) begin
            lane = int'(off) + j;
            if (we && (j < nbytes) && (lane < 4)) begin
                ps_d.ptr[{lane[1:0], 3'b000} +: 8] = wdata[8*j +: 8];
            end
        end
        ps_d.ptr[1:0] = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign ptr = ps_q.ptr;

    // R10: an aligned word write loads the whole pointer, low bits dropped
    a_r10_word_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && size == SZ_WORD && off == 2'd0) |=> (ptr == {$past(wdata[31:2]), 2'b00}));

endmodule

// File: rtl/ide_bm_rdmux.sv
module ide_bm_rdmux
    import ide_bm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int AW     = 4
) (
    input  logic [AW-1:0]                addr,
    input  io_size_e                     size,
    input  logic [NUM_CH-1:0][7:0]       cmd_b,
    input  logic [NUM_CH-1:0][7:0]       sts_b,
    input  logic [NUM_CH-1:0][31:0]      ptr_w,
    output logic [31:0]                  rdata
);

    localparam int CHW = AW - 3;

    logic [CHW-1:0] ch;
    logic [1:0]     off;
    logic [31:0]    mask;

    always_comb begin
        ch    = addr[AW-1:3];
        off   = addr[1:0];
        mask  = size_mask(size);
        rdata = mask;
        if (int'(ch) < NUM_CH) begin
            if (addr[2]) begin
                rdata = (ptr_w[ch] >> {off, 3'b000}) & mask;
            end else if (size == SZ_BYTE) begin
                case (int'(off))
                    CMD_OFF: rdata = {24'h0, cmd_b[ch]};
                    STS_OFF: rdata = {24'h0, sts_b[ch]};
                    default: rdata = 32'h0000_00FF;
                endcase
            end
        end
    end

endmodule

// File: rtl/ide_busmaster_regs.sv
module ide_busmaster_regs
    import ide_bm_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int AW     = $clog2(NUM_CH * SLICE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         io_addr,
    input  logic [1:0]            io_size,
    input  logic                  io_wr,
    input  logic [31:0]           io_wdata,
    output logic [31:0]           io_rdata,
    input  logic [NUM_CH-1:0]     eng_active,
    input  logic [NUM_CH-1:0]     eng_irq,
    input  logic [NUM_CH-1:0]     eng_err,
    output logic [NUM_CH-1:0]     ch_start,
    output logic [NUM_CH-1:0]     ch_dir,
    output logic [NUM_CH*32-1:0]  ch_ptr
);

    localparam int CHW = AW - 3;

    io_size_e                 size_e;
    logic [CHW-1:0]           ch_sel;
    logic [1:0]               off;
    logic [NUM_CH-1:0][7:0]   cmd_b;
    logic [NUM_CH-1:0][7:0]   sts_b;
    logic [NUM_CH-1:0][31:0]  ptr_w;
    logic [31:0]              rdata_d, rdata_q;

    assign size_e = io_size_e'(io_size);
    assign ch_sel = io_addr[AW-1:3];
    assign off    = io_addr[1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit, cmd_we, sts_we, ptr_we;

        assign hit    = io_wr && (ch_sel == CHW'(i));
        assign cmd_we = hit && !io_addr[2] && (size_e == SZ_BYTE) && (off == 2'(CMD_OFF));
        assign sts_we = hit && !io_addr[2] && (size_e == SZ_BYTE) && (off == 2'(STS_OFF));
        assign ptr_we = hit && io_addr[2];

        ide_bm_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_we     (cmd_we),
            .sts_we     (sts_we),
            .wbyte      (io_wdata[7:0]),
            .eng_active (eng_active[i]),
            .eng_irq    (eng_irq[i]),
            .eng_err    (eng_err[i]),
            .start      (ch_start[i]),
            .dir        (ch_dir[i]),
            .sts        (sts_b[i])
        );

        ide_bm_ptr u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (ptr_we),
            .off   (off),
            .size  (size_e),
            .wdata (io_wdata),
            .ptr   (ptr_w[i])
        );

        always_comb begin
            cmd_b[i] = 8'h00;
            cmd_b[i][CMD_START_BIT] = ch_start[i];
            cmd_b[i][CMD_DIR_BIT]   = ch_dir[i];
        end

        assign ch_ptr[32*i +: 32] = ptr_w[i];
    end

    ide_bm_rdmux #(
        .NUM_CH (NUM_CH),
        .AW     (AW)
    ) u_rdmux (
        .addr  (io_addr),
        .size  (size_e),
        .cmd_b (cmd_b),
        .sts_b (sts_b),
        .ptr_w (ptr_w),
        .rdata (rdata_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign io_rdata = rdata_q;

    // R3: halfword access to the command/status area reads as ones
    a_r3_half_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_addr[2] && io_size == 2'd1) |=> (io_rdata == 32'h0000_FFFF));

    // R4: wide writes to the command/status area leave the command bits alone
    a_r4_wide_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_addr[2] && io_size != 2'd0) |=> ($stable(ch_start) && $stable(ch_dir)));

endmodule

// File: tb/ide_busmaster_regs_tb.sv
module ide_busmaster_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [1:0]  eng_active = '0;
    logic [1:0]  eng_irq = '0;
    logic [1:0]  eng_err = '0;
    logic [1:0]  ch_start;
    logic [1:0]  ch_dir;
    logic [63:0] ch_ptr;

    always #5 clk = ~clk;

    ide_busmaster_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_size    (io_size),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .eng_active (eng_active),
        .eng_irq    (eng_irq),
        .eng_err    (eng_err),
        .ch_start   (ch_start),
        .ch_dir     (ch_dir),
        .ch_ptr     (ch_ptr)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R12";

    logic        m_start [2];
    logic        m_dir   [2];
    logic [7:0]  m_sts   [2];
    logic [31:0] m_ptr   [2];
    logic [31:0] m_rd;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [3:0] a, logic [1:0] s);
        int c = int'(a[3]);
        int o = int'(a[1:0]);
        logic [31:0] m = (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        if (a[2]) return (m_ptr[c] >> (8 * o)) & m;
        if (s != 2'd0) return m;
        if (o == 0) return {24'h0, 4'h0, m_dir[c], 2'b00, m_start[c]};
        if (o == 2) return {24'h0, m_sts[c]};
        return 32'hFF;
    endfunction

    task automatic model_update();
        int c = int'(io_addr[3]);
        int o = int'(io_addr[1:0]);
        int n = (io_size == 2'd0) ? 1 : (io_size == 2'd1) ? 2 : 4;
        if (io_wr) begin
            if (io_addr[2]) begin
                for (int j = 0; j < n; j++) begin
                    if (o + j < 4) m_ptr[c][8*(o+j) +: 8] = io_wdata[8*j +: 8];
                end
                m_ptr[c][1:0] = 2'b00;
            end else if (io_size == 2'd0 && o == 0) begin
                m_start[c] = io_wdata[0];
                m_dir[c]   = io_wdata[3];
            end else if (io_size == 2'd0 && o == 2) begin
                m_sts[c] = (io_wdata[7:0] & 8'h60) | (m_sts[c] & 8'h06 & ~io_wdata[7:0]);
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (eng_irq[k]) m_sts[k][2] = 1'b1;
            if (eng_err[k]) m_sts[k][1] = 1'b1;
            m_sts[k][0] = eng_active[k];
        end
    endtask

    task automatic tick();
        logic [31:0] nrd;
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_start[k] = 0; m_dir[k] = 0; m_sts[k] = 0; m_ptr[k] = 0;
            end
            nrd = 0;
        end else begin
            nrd = model_read(io_addr, io_size);
            model_update();
        end
        @(posedge clk);
        #2;
        m_rd = nrd;
        check(cur_req, "rdata", io_rdata, m_rd);
        check(cur_req, "start/dir", {28'h0, ch_dir, ch_start}, {28'h0, m_dir[1], m_dir[0], m_start[1], m_start[0]});
        check(cur_req, "ptr0", ch_ptr[31:0], m_ptr[0]);
        check(cur_req, "ptr1", ch_ptr[63:32], m_ptr[1]);
    endtask

    task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
        io_addr = a; io_size = s; io_wdata = d; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic rd_expect(string req, logic [3:0] a, logic [1:0] s, logic [31:0] exp);
        io_addr = a; io_size = s;
        tick();
        check(req, "read", io_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) tick();
        rst_n = 1'b1;
        rd_expect("R12", 4'h0, 2'd0, 32'h0);
        rd_expect("R12", 4'h2, 2'd0, 32'h0);
        rd_expect("R12", 4'hC, 2'd2, 32'h0);

        // R5: command bits
        cur_req = "R5";
        wr(4'h0, 2'd0, 32'h0000_00FF);
        rd_expect("R5", 4'h0, 2'd0, 32'h09);
        check("R5", "start0", {31'h0, ch_start[0]}, 32'h1);
        wr(4'h8, 2'd0, 32'h0000_0008);
        rd_expect("R5", 4'h8, 2'd0, 32'h08);

        // R1: channel map
        cur_req = "R1";
        wr(4'hC, 2'd2, 32'h1234_5677);
        check("R1", "ptr1", ch_ptr[63:32], 32'h1234_5674);
        check("R1", "ptr0 untouched", ch_ptr[31:0], 32'h0);

        // R10: pointer lane writes
        cur_req = "R10";
        wr(4'h5, 2'd0, 32'h0000_00AB);
        wr(4'h6, 2'd1, 32'h0000_CDEF);
        check("R10", "half@6", ch_ptr[31:0], 32'hCDEF_AB00);
        wr(4'h7, 2'd1, 32'h0000_5511);
        check("R10", "half@7 drops lane", ch_ptr[31:0], 32'h11EF_AB00);
        wr(4'h4, 2'd0, 32'h0000_00FF);
        check("R10", "low bits", ch_ptr[31:0], 32'h11EF_ABFC);
        wr(4'h5, 2'd2, 32'hA1B2_C3D4);

        // R11: pointer reads
        cur_req = "R11";
        rd_expect("R11", 4'h4, 2'd2, 32'hB2C3_D4FC);
        rd_expect("R11", 4'h5, 2'd0, 32'h0000_00D4);
        rd_expect("R11", 4'h6, 2'd1, 32'h0000_B2C3);
        rd_expect("R11", 4'hD, 2'd3, 32'h0012_3456);

        // R2 / R3: command/status reads
        cur_req = "R2";
        rd_expect("R2", 4'h1, 2'd0, 32'hFF);
        rd_expect("R2", 4'hB, 2'd0, 32'hFF);
        cur_req = "R3";
        rd_expect("R3", 4'h0, 2'd1, 32'h0000_FFFF);
        rd_expect("R3", 4'hA, 2'd2, 32'hFFFF_FFFF);
        rd_expect("R3", 4'h2, 2'd3, 32'hFFFF_FFFF);

        // R4: wide writes dropped
        cur_req = "R4";
        wr(4'h0, 2'd2, 32'h0);
        wr(4'h2, 2'd1, 32'hFFFF);
        rd_expect("R4", 4'h0, 2'd0, 32'h09);
        rd_expect("R4", 4'h2, 2'd0, 32'h00);

        // R6: status plain bits and zero bits
        cur_req = "R6";
        wr(4'h2, 2'd0, 32'hFF);
        rd_expect("R6", 4'h2, 2'd0, 32'h60);
        wr(4'h2, 2'd0, 32'h20);
        rd_expect("R6", 4'h2, 2'd0, 32'h20);

        // R7: engine-owned active bit
        cur_req = "R7";
        eng_active = 2'b01;
        tick();
        wr(4'h2, 2'd0, 32'h00);
        rd_expect("R7", 4'h2, 2'd0, 32'h01);
        eng_active = 2'b00;
        tick();
        rd_expect("R7", 4'h2, 2'd0, 32'h00);

        // R9: event pulses set the flags
        cur_req = "R9";
        eng_irq = 2'b10; eng_err = 2'b10;
        tick();
        eng_irq = 2'b00; eng_err = 2'b00;
        rd_expect("R9", 4'hA, 2'd0, 32'h06);

        // R8: write-one-to-clear
        cur_req = "R8";
        wr(4'hA, 2'd0, 32'h00);
        rd_expect("R8", 4'hA, 2'd0, 32'h06);
        wr(4'hA, 2'd0, 32'h04);
        rd_expect("R8", 4'hA, 2'd0, 32'h02);

        // R9: set wins over a same-cycle clear
        cur_req = "R9";
        io_addr = 4'hA; io_size = 2'd0; io_wdata = 32'h06; io_wr = 1'b1;
        eng_irq = 2'b10;
        tick();
        io_wr = 1'b0; eng_irq = 2'b00;
        rd_expect("R9", 4'hA, 2'd0, 32'h04);

        // R13: reads are side-effect free and take one cycle
        cur_req = "R13";
        rd_expect("R13", 4'hA, 2'd0, 32'h04);
        rd_expect("R13", 4'hA, 2'd0, 32'h04);
        io_addr = 4'h0;
        tick();
        check("R13", "latency", io_rdata, 32'h09);

        // R5: clearing start
        cur_req = "R5";
        wr(4'h0, 2'd0, 32'h00);
        check("R5", "stop", {31'h0, ch_start[0]}, 32'h0);

        // R12: reset mid-run
        cur_req = "R12";
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        rd_expect("R12", 4'hA, 2'd0, 32'h0);
        check("R12", "ptrs", ch_ptr[31:0] | ch_ptr[63:32], 32'h0);
        check("R12", "start/dir", {28'h0, ch_dir, ch_start}, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule